// File: doc/BRIEF.md
# Outbound Mailbox Read Controller

This block hands a response message from firmware to a host, one word at a time. Firmware places the message in a window of shared SRAM, sets the window's first and last word address and marks the window as valid. It then writes the message length in words. The controller fetches each word through a request/grant/response SRAM port and holds it in a read-data output. It raises a ready flag while a word is on offer. Each host read consumes the word and starts the fetch of the next one, until the remaining length runs out.

The host may abandon a transfer with an abort request. The controller then drops ready, blanks the read data and waits for firmware to acknowledge. The acknowledge acts as a full reset of the transfer logic and takes priority over every other input. It clears the remaining length, the outstanding-response count and the error flag. Any SRAM response that was still in flight is discarded when it arrives. Single-cycle event outputs mark entry into the word-ready state and into the aborted state, for an interrupt block outside.

Top module: `mbx_ob_reader`

## Requirements
- R1: After reset, ready, abort_pending, range_err, sram_req and obj_size_left are all zero, and rd_data is zero.
- R2: On each rising edge of cfg_range_valid the read pointer loads cfg_base. Words are then delivered from consecutive addresses, base first.
- R3: While cfg_range_valid is low, sram_req stays low.
- R4: obj_size_left drops by exactly one for each granted SRAM request (sram_req and sram_gnt high in the same cycle), whether the grant comes in the first cycle of the request or later. obj_size_wr loads obj_size_in only while the block is idle.
- R5: Once ready is high, it stays high and rd_data stays constant until a host read, an abort request or an abort acknowledge.
- R6: A host read when obj_size_left is zero drops ready in the next cycle, and no further request is made.
- R7: cfg_limit is inclusive. A word is fetched only from an address at or below it. When the next word would lie past it, range_err is set, no request is issued and ready stays low.
- R8: An abort request drops ready and raises abort_pending in the next cycle. rd_data reads zero and host reads have no effect until fw_abort_ack.
- R9: fw_abort_ack returns the block to idle in the next cycle, even with an abort request in the same cycle. It clears abort_pending, range_err, obj_size_left and rd_data, and it reloads the pointer from cfg_base.
- R10: An SRAM response that arrives after an acknowledge is discarded: ready stays low and rd_data stays zero.
- R11: ready_evt pulses for exactly one cycle, in the cycle before ready rises. abort_evt pulses for one cycle, in the cycle before abort_pending rises. Neither pulses on an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | First word address of the window |
| cfg_limit | input | AW | Last usable word address of the window (inclusive) |
| cfg_range_valid | input | 1 | Window configuration is valid |
| obj_size_wr | input | 1 | Load strobe for the message length |
| obj_size_in | input | SW | Message length in words |
| host_rd | input | 1 | Host consumed the current read-data word |
| host_abort_req | input | 1 | Host abandons the transfer |
| fw_abort_ack | input | 1 | Firmware acknowledge; resets the transfer logic |
| sram_req | output | 1 | SRAM read request |
| sram_addr | output | AW | SRAM word address |
| sram_gnt | input | 1 | SRAM request accepted |
| sram_rvalid | input | 1 | SRAM read response valid |
| sram_rdata | input | DW | SRAM read response data |
| rd_data | output | DW | Word offered to the host |
| ready | output | 1 | A word is on offer |
| abort_pending | output | 1 | Abort waiting for acknowledge |
| range_err | output | 1 | A fetch past the limit was refused |
| obj_size_left | output | SW | Words not yet fetched |
| ready_evt | output | 1 | One-cycle pulse on entry to the ready state |
| abort_evt | output | 1 | One-cycle pulse on entry to the abort state |

## Verification
The bench varies the grant latency. A design that counted the length only on first-cycle grants would show an obj_size_left that lags behind the number of delivered words. A window that ends exactly at its limit must deliver every word. One that ends too early must stop with range_err: an exclusive limit compare loses the last word, and a missing compare reads past the window. A response is held back across an acknowledge and then released. A design that kept its outstanding count would capture that stale word or raise ready, and one that skipped the pointer reload would fetch from the wrong address next. An acknowledge in the same cycle as an abort request must win, and a design that ranked abort higher would be left pending.

// File: rtl/mbx_ob_pkg.sv
// Shared types for the outbound mailbox read controller.
package mbx_ob_pkg;
    // Controller states; encoding carries no external meaning.
    typedef enum logic [2:0] {
        OB_IDLE  = 3'd0,
        OB_FETCH = 3'd1,
        OB_WAIT  = 3'd2,
        OB_READ  = 3'd3,
        OB_ABORT = 3'd4
    } ob_state_e;
endpackage

// File: rtl/ob_ptr_unit.sv
// Read pointer and remaining-length counter.
// Assumes: flush has top priority; the pointer carries one extra bit so that
// stepping past the top of the address space never wraps into range.
module ob_ptr_unit #(
    parameter int AW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic          range_valid,
    input  logic          flush,
    input  logic          size_load,
    input  logic [SW-1:0] size_in,
    input  logic          fetch_acc,
    output logic [AW-1:0] rd_addr,
    output logic [SW-1:0] size_left,
    output logic          size_zero,
    output logic          ptr_in_range
);
    localparam int PW = AW + 1;

    logic          range_q;
    logic [PW-1:0] ptr_q;
    logic [SW-1:0] size_q;
    logic          range_rise;

    assign range_rise = range_valid && !range_q;

    // Remember the previous range-valid level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) range_q <= 1'b0;
        else        range_q <= range_valid;
    end

    // Pointer: reload on flush or range rise, step on each accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)            ptr_q <= '0;
        else if (flush)        ptr_q <= {1'b0, cfg_base};
        else if (range_rise)   ptr_q <= {1'b0, cfg_base};
        else if (fetch_acc)    ptr_q <= ptr_q + 1'b1;
    end

    // Remaining length: load on write, count down on each accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                       size_q <= '0;
        else if (flush)                   size_q <= '0;
        else if (size_load)               size_q <= size_in;
        else if (fetch_acc && size_q != '0) size_q <= size_q - 1'b1;
    end

    assign rd_addr      = ptr_q[AW-1:0];
    assign size_left    = size_q;
    assign size_zero    = (size_q == '0);
    assign ptr_in_range = (ptr_q <= {1'b0, cfg_limit});
endmodule

// File: rtl/ob_rsp_unit.sv
// Outstanding-response tracking and read-word capture.
// Assumes: responses return in order; a response with no outstanding request
// (e.g. one that arrives after a flush) is dropped.
module ob_rsp_unit #(
    parameter int DW        = 32,
    parameter int MAX_OUTST = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          issue,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    input  logic          capture_en,
    output logic          rsp_take,
    output logic [DW-1:0] word_q
);
    localparam int OW = $clog2(MAX_OUTST + 1);
    localparam logic [OW-1:0] OMAX = OW'(MAX_OUTST);

    logic [OW-1:0] outst_q;
    logic          inc, dec;

    assign rsp_take = rsp_valid && (outst_q != '0) && !flush;
    assign inc      = issue && (outst_q != OMAX);
    assign dec      = rsp_take;

    // Count requests granted but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n)          outst_q <= '0;
        else if (flush)      outst_q <= '0;
        else if (inc && !dec) outst_q <= outst_q + 1'b1;
        else if (dec && !inc) outst_q <= outst_q - 1'b1;
    end

    // Hold the word offered to the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                      word_q <= '0;
        else if (flush)                  word_q <= '0;
        else if (rsp_take && capture_en) word_q <= rsp_data;
    end
endmodule

// File: rtl/ob_ctrl_fsm.sv
// Transfer sequencing: fetch, wait, offer, abort; edge events and error flag.
// Assumes: the acknowledge outranks the abort request, which outranks all else.
module ob_ctrl_fsm
    import mbx_ob_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      range_valid,
    input  logic      size_zero,
    input  logic      ptr_in_range,
    input  logic      sram_gnt,
    input  logic      rsp_take,
    input  logic      host_rd,
    input  logic      abort_req,
    input  logic      abort_ack,
    output ob_state_e state,
    output logic      sram_req,
    output logic      err,
    output logic      ready_evt,
    output logic      abort_evt
);
    ob_state_e state_q, state_d;
    logic      err_q, err_set;

    assign sram_req = (state_q == OB_FETCH) && range_valid;

    // Next-state selection with acknowledge and abort priority.
    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        if (abort_ack) begin
            state_d = OB_IDLE;
        end else if (abort_req && state_q != OB_ABORT) begin
            state_d = OB_ABORT;
        end else begin
            case (state_q)
                OB_IDLE: begin
                    if (range_valid && !size_zero) begin
                        if (ptr_in_range) state_d = OB_FETCH;
                        else              err_set = 1'b1;
                    end
                end
                OB_FETCH: if (sram_req && sram_gnt) state_d = OB_WAIT;
                OB_WAIT:  if (rsp_take) state_d = OB_READ;
                OB_READ: begin
                    if (host_rd) begin
                        if (size_zero)         state_d = OB_IDLE;
                        else if (ptr_in_range) state_d = OB_FETCH;
                        else begin
                            err_set = 1'b1;
                            state_d = OB_IDLE;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OB_IDLE;
        else        state_q <= state_d;
    end

    // Sticky range error, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (abort_ack) err_q <= 1'b0;
        else if (err_set)  err_q <= 1'b1;
    end

    assign state     = state_q;
    assign err       = err_q;
    assign ready_evt = (state_q != OB_READ)  && (state_d == OB_READ);
    assign abort_evt = (state_q != OB_ABORT) && (state_d == OB_ABORT);
endmodule

// File: rtl/mbx_ob_reader.sv
// Outbound mailbox read controller top: fetches a firmware message word by
// word from an SRAM window and offers each word to the host.
// Assumes: cfg_base/cfg_limit are stable while cfg_range_valid is high.
module mbx_ob_reader
    import mbx_ob_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int SW        = 8,
    parameter int MAX_OUTST = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic          cfg_range_valid,
    input  logic          obj_size_wr,
    input  logic [SW-1:0] obj_size_in,
    input  logic          host_rd,
    input  logic          host_abort_req,
    input  logic          fw_abort_ack,
    output logic          sram_req,
    output logic [AW-1:0] sram_addr,
    input  logic          sram_gnt,
    input  logic          sram_rvalid,
    input  logic [DW-1:0] sram_rdata,
    output logic [DW-1:0] rd_data,
    output logic          ready,
    output logic          abort_pending,
    output logic          range_err,
    output logic [SW-1:0] obj_size_left,
    output logic          ready_evt,
    output logic          abort_evt
);
    ob_state_e     state;
    logic          size_zero, in_range, fetch_acc, rsp_take, size_load;
    logic [DW-1:0] word_q;

    assign fetch_acc = sram_req && sram_gnt;
    assign size_load = obj_size_wr && (state == OB_IDLE) && !fw_abort_ack;

    ob_ptr_unit #(.AW(AW), .SW(SW)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_base     (cfg_base),
        .cfg_limit    (cfg_limit),
        .range_valid  (cfg_range_valid),
        .flush        (fw_abort_ack),
        .size_load    (size_load),
        .size_in      (obj_size_in),
        .fetch_acc    (fetch_acc),
        .rd_addr      (sram_addr),
        .size_left    (obj_size_left),
        .size_zero    (size_zero),
        .ptr_in_range (in_range)
    );

    ob_rsp_unit #(.DW(DW), .MAX_OUTST(MAX_OUTST)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (fw_abort_ack),
        .issue      (fetch_acc),
        .rsp_valid  (sram_rvalid),
        .rsp_data   (sram_rdata),
        .capture_en (state == OB_WAIT),
        .rsp_take   (rsp_take),
        .word_q     (word_q)
    );

    ob_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .range_valid  (cfg_range_valid),
        .size_zero    (size_zero),
        .ptr_in_range (in_range),
        .sram_gnt     (sram_gnt),
        .rsp_take     (rsp_take),
        .host_rd      (host_rd),
        .abort_req    (host_abort_req),
        .abort_ack    (fw_abort_ack),
        .state        (state),
        .sram_req     (sram_req),
        .err          (range_err),
        .ready_evt    (ready_evt),
        .abort_evt    (abort_evt)
    );

    assign ready         = (state == OB_READ);
    assign abort_pending = (state == OB_ABORT);
    assign rd_data       = abort_pending ? '0 : word_q;
endmodule

// File: rtl/ob_reader_chk.sv
// Port-level properties of the outbound mailbox read controller, bound to the top.
module ob_reader_chk #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cfg_limit,
    input logic          cfg_range_valid,
    input logic          host_rd,
    input logic          host_abort_req,
    input logic          fw_abort_ack,
    input logic          sram_req,
    input logic [AW-1:0] sram_addr,
    input logic          sram_gnt,
    input logic [DW-1:0] rd_data,
    input logic          ready,
    input logic          abort_pending,
    input logic          range_err,
    input logic [SW-1:0] obj_size_left,
    input logic          ready_evt,
    input logic          abort_evt
);
    assert_req_needs_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sram_req |-> cfg_range_valid);

    assert_addr_within_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_req |-> (sram_addr <= cfg_limit));

    assert_size_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_req && sram_gnt && obj_size_left != '0 && !fw_abort_ack)
        |=> obj_size_left == $past(obj_size_left) - 1'b1);

    assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !host_rd && !host_abort_req && !fw_abort_ack)
        |=> (ready && $stable(rd_data)));

    assert_last_read_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && host_rd && obj_size_left == '0 && !host_abort_req && !fw_abort_ack)
        |=> !ready);

    assert_abort_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_abort_req && !fw_abort_ack) |=> (!ready && abort_pending && rd_data == '0));

    assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fw_abort_ack |=> (!ready && !abort_pending && !range_err && obj_size_left == '0));

    assert_ready_evt_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ready_evt |=> (ready && !ready_evt));

    assert_abort_evt_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (abort_pending && !abort_evt));

    assert_no_evt_on_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fw_abort_ack |-> (!ready_evt && !abort_evt));
endmodule

bind mbx_ob_reader ob_reader_chk #(.AW(AW), .DW(DW), .SW(SW)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_limit       (cfg_limit),
    .cfg_range_valid (cfg_range_valid),
    .host_rd         (host_rd),
    .host_abort_req  (host_abort_req),
    .fw_abort_ack    (fw_abort_ack),
    .sram_req        (sram_req),
    .sram_addr       (sram_addr),
    .sram_gnt        (sram_gnt),
    .rd_data         (rd_data),
    .ready           (ready),
    .abort_pending   (abort_pending),
    .range_err       (range_err),
    .obj_size_left   (obj_size_left),
    .ready_evt       (ready_evt),
    .abort_evt       (abort_evt)
);

// File: tb/test_mbx_ob_reader.sv
`timescale 1ns/1ps
module test_mbx_ob_reader;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int SW = 8;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] limit;
        logic [7:0] size;
        logic [7:0] delay;
        logic [7:0] exp_words;
        logic       exp_err;
    } vec_t;

    // base, limit, size, grant delay, words expected, error expected
    localparam vec_t VECS [4] = '{
        '{8'd4,  8'd7,  8'd3, 8'd0, 8'd3, 1'b0},
        '{8'd10, 8'd13, 8'd4, 8'd2, 8'd4, 1'b0},
        '{8'd20, 8'd21, 8'd4, 8'd1, 8'd2, 1'b1},
        '{8'd30, 8'd40, 8'd1, 8'd3, 8'd1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
    logic          cfg_range_valid = 1'b0;
    logic          obj_size_wr = 1'b0;
    logic [SW-1:0] obj_size_in = '0;
    logic          host_rd = 1'b0, host_abort_req = 1'b0, fw_abort_ack = 1'b0;
    logic          sram_req, sram_gnt;
    logic [AW-1:0] sram_addr;
    logic          sram_rvalid;
    logic [DW-1:0] sram_rdata;
    logic [DW-1:0] rd_data;
    logic          ready, abort_pending, range_err, ready_evt, abort_evt;
    logic [SW-1:0] obj_size_left;

    int n_checks = 0, n_fail = 0;
    int n_rdy_evt = 0, n_ab_evt = 0, n_req = 0;
    bit done = 1'b0;
    logic [7:0] gnt_delay = '0, wait_cnt;
    logic       hold_rsp = 1'b0, release_rsp = 1'b0, held;
    logic [AW-1:0] held_addr;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return 32'h5A00_0000 | (32'(a) * 32'd7);
    endfunction

    mbx_ob_reader i_mbx_ob_reader (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_range_valid(cfg_range_valid), .obj_size_wr(obj_size_wr),
        .obj_size_in(obj_size_in), .host_rd(host_rd), .host_abort_req(host_abort_req),
        .fw_abort_ack(fw_abort_ack), .sram_req(sram_req), .sram_addr(sram_addr),
        .sram_gnt(sram_gnt), .sram_rvalid(sram_rvalid), .sram_rdata(sram_rdata),
        .rd_data(rd_data), .ready(ready), .abort_pending(abort_pending),
        .range_err(range_err), .obj_size_left(obj_size_left),
        .ready_evt(ready_evt), .abort_evt(abort_evt)
    );

    // SRAM model: grant after gnt_delay waiting cycles, answer one cycle later.
    assign sram_gnt = sram_req && (wait_cnt >= gnt_delay);
    always @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0; sram_rvalid <= 1'b0; sram_rdata <= '0; held <= 1'b0; held_addr <= '0;
        end else begin
            wait_cnt    <= (sram_req && !sram_gnt) ? wait_cnt + 8'd1 : 8'd0;
            sram_rvalid <= 1'b0;
            if (sram_req && sram_gnt) begin
                if (hold_rsp) begin held <= 1'b1; held_addr <= sram_addr; end
                else begin sram_rvalid <= 1'b1; sram_rdata <= mem_word(sram_addr); end
            end else if (release_rsp && held) begin
                sram_rvalid <= 1'b1; sram_rdata <= mem_word(held_addr); held <= 1'b0;
            end
        end
    end

    // Event and request counters.
    always @(posedge clk) begin
        if (rst_n) begin
            if (ready_evt) n_rdy_evt <= n_rdy_evt + 1;
            if (abort_evt) n_ab_evt  <= n_ab_evt + 1;
            if (sram_req)  n_req     <= n_req + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        fw_abort_ack = 1'b1; cyc(1); fw_abort_ack = 1'b0;
    endtask

    task automatic write_size(input logic [SW-1:0] s);
        obj_size_in = s; obj_size_wr = 1'b1; cyc(1); obj_size_wr = 1'b0;
    endtask

    task automatic set_range(input logic [7:0] b, input logic [7:0] l);
        cfg_range_valid = 1'b0; cyc(1);
        cfg_base = b; cfg_limit = l; cfg_range_valid = 1'b1; cyc(1);
    endtask

    task automatic wait_ready(output bit got);
        got = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (ready) begin got = 1'b1; break; end
            cyc(1);
        end
    endtask

    task automatic host_read();
        host_rd = 1'b1; cyc(1); host_rd = 1'b0;
    endtask

    initial begin
        bit got;
        int words, evt0, req0;
        cyc(3);
        // R1: reset state
        check(!ready && !abort_pending && !range_err && !sram_req, "R1 flags", {ready, abort_pending, range_err, sram_req}, 0);
        check(obj_size_left == 0 && rd_data == 0, "R1 size/data", rd_data, 0);
        rst_n = 1'b1; cyc(1);

        // R3: no request while range invalid, even with a length loaded
        cfg_base = 8'h40; cfg_limit = 8'h4F;
        write_size(8'd2);
        cyc(20);
        check(n_req == 0, "R3 no req while invalid", n_req, 0);
        check(obj_size_left == 2, "R4 size load in idle", obj_size_left, 2);
        // R2: pointer loads base on range rise
        cfg_range_valid = 1'b1;
        wait_ready(got);
        check(got && rd_data == mem_word(8'h40), "R2 first word from base", rd_data, mem_word(8'h40));
        cyc(10);
        check(ready && rd_data == mem_word(8'h40), "R5 ready held", {31'd0, ready}, 1);
        host_read();
        wait_ready(got);
        check(got && rd_data == mem_word(8'h41), "R2 consecutive word", rd_data, mem_word(8'h41));
        check(obj_size_left == 0, "R4 size after last fetch", obj_size_left, 0);
        req0 = n_req;
        host_read();
        check(!ready, "R6 ready drops after last read", {31'd0, ready}, 0);
        cyc(10);
        check(n_req == req0 && !ready, "R6 idle, no new request", n_req, req0);

        // Vector table
        foreach (VECS[v]) begin
            pulse_ack();
            set_range(VECS[v].base, VECS[v].limit);
            gnt_delay = VECS[v].delay;
            evt0 = n_rdy_evt;
            write_size(VECS[v].size);
            words = 0;
            for (int k = 0; k < 8; k++) begin
                wait_ready(got);
                if (!got) break;
                check(rd_data == mem_word(VECS[v].base + 8'(words)), "R2 table word", rd_data, mem_word(VECS[v].base + 8'(words)));
                check(obj_size_left == VECS[v].size - 8'(words) - 8'd1, "R4 table size", obj_size_left, VECS[v].size - 8'(words) - 8'd1);
                host_read();
                words++;
            end
            check(words == int'(VECS[v].exp_words), "R7 table word count", words, VECS[v].exp_words);
            check(range_err == VECS[v].exp_err, "R7 table limit error", {31'd0, range_err}, {31'd0, VECS[v].exp_err});
            check(n_rdy_evt - evt0 == words, "R11 one ready event per word", n_rdy_evt - evt0, words);
        end
        gnt_delay = '0;

        // R8: abort while a word is on offer
        pulse_ack();
        set_range(8'd4, 8'd9);
        write_size(8'd2);
        wait_ready(got);
        evt0 = n_ab_evt;
        host_abort_req = 1'b1; cyc(1); host_abort_req = 1'b0;
        check(!ready && abort_pending && rd_data == 0, "R8 abort blanks data", rd_data, 0);
        check(n_ab_evt == evt0 + 1, "R11 abort event once", n_ab_evt, evt0 + 1);
        host_read(); cyc(5);
        check(abort_pending && rd_data == 0 && !ready, "R8 host read ignored", {31'd0, abort_pending}, 1);
        check(n_ab_evt == evt0 + 1, "R11 abort event single", n_ab_evt, evt0 + 1);
        pulse_ack();
        check(!abort_pending && !ready && obj_size_left == 0 && !range_err, "R9 ack clears", {abort_pending, ready, range_err}, 0);

        // R9: acknowledge outranks a simultaneous abort request
        write_size(8'd1);
        wait_ready(got);
        host_abort_req = 1'b1; fw_abort_ack = 1'b1; cyc(1);
        host_abort_req = 1'b0; fw_abort_ack = 1'b0;
        check(!abort_pending && !ready, "R9 ack beats abort", {30'd0, abort_pending, ready}, 0);

        // R10: response held across an acknowledge is dropped
        set_range(8'd50, 8'd60);
        hold_rsp = 1'b1;
        write_size(8'd2);
        cyc(6);
        pulse_ack();
        hold_rsp = 1'b0;
        release_rsp = 1'b1; cyc(1); release_rsp = 1'b0;
        cyc(5);
        check(!ready && rd_data == 0, "R10 late response dropped", rd_data, 0);
        write_size(8'd1);
        wait_ready(got);
        check(got && rd_data == mem_word(8'd50), "R9 pointer reloaded by ack", rd_data, mem_word(8'd50));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog (all): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule